// File: doc/BRIEF.md
# Tristate Strap Identifier Reader

This block reads a group of board-strap pins, each of which may be wired to ground, wired to the supply, or left open, and turns them into a single base-3 board identifier. It tells the three cases apart by pulling each pin one way and then the other. A pin wired to a rail keeps its level under both pulls. An open pin follows whichever pull is applied.

A one-cycle `start` begins a read, and the block then drives the pad controls itself. Every pin gets its input buffer on, its output driver off, its interrupt off and its function set to general-purpose I/O. The pull-up is applied first. After a settling time the pins are sampled, then the pull-down is applied, and after a second settling time they are sampled again. Both settling times are counted in clock cycles derived from the clock frequency. The two samples of each pin give one digit. The digits are folded serially into the identifier, one per clock, with pin 0 as the least significant digit. The pulls are then released and `done` pulses. The identifier stays on `id_out` until the next read finishes.

Top module: `strap_ternary_reader`

## Requirements
- R1: While reset is held and in the cycle after it, busy, done, id_out, all pull codes, in_buf_en, gpio_sel, out_drv_en and irq_en are zero.
- R2: From the edge that accepts a start until done, every pin has in_buf_en = 1, gpio_sel = 1, out_drv_en = 0 and irq_en = 0, and busy = 1.
- R3: Each pin has a 2-bit pull code at pull_sel[2i+1:2i]: 2'b00 none, 2'b01 pull-up, 2'b10 pull-down. 2'b11 never appears. All pins carry the same code. A read applies pull-up first and pull-down second.
- R4: The pull-up phase lasts S clock cycles, starting at the accepting edge, and the pull-down phase starts S cycles after that edge. S = max(ceil(CLK_FREQ_HZ * SETTLE_US / 10^6), SYNC_STAGES + 1). Pin inputs pass through SYNC_STAGES flops before they are sampled.
- R5: A pin's digit is down_sample | ((up_sample ^ down_sample) << 1). This gives 0 for a pin tied low, 1 for a pin tied high and 2 for an open pin.
- R6: id_out = sum over i of digit_i * 3^i, with pin 0 as the least significant ternary digit. It never exceeds 3^NUM_PINS - 1.
- R7: done is a one-cycle pulse. It rises 2S + NUM_PINS cycles after the accepting edge, in the same cycle that busy falls, and the two are never high together.
- R8: When done rises, all pull codes are none while in_buf_en and gpio_sel stay 1. Pull codes stay none whenever busy is 0.
- R9: id_out changes only in the cycle that done rises. A start while busy is 1 has no effect on the timing or the result of the read in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | One-cycle request to begin a read |
| pin_in | input | NUM_PINS | Asynchronous strap pin levels |
| busy | output | 1 | A read is in progress |
| done | output | 1 | One-cycle pulse when id_out is updated |
| id_out | output | ID_W | Ternary identifier, held until the next done |
| pull_sel | output | 2*NUM_PINS | Per-pin pull code (00 none, 01 up, 10 down) |
| in_buf_en | output | NUM_PINS | Per-pin input buffer enable |
| out_drv_en | output | NUM_PINS | Per-pin output driver enable (kept off) |
| irq_en | output | NUM_PINS | Per-pin interrupt enable (kept off) |
| gpio_sel | output | NUM_PINS | Per-pin general-purpose I/O function select |

## Verification
The properties assume that `start` is a single-cycle pulse and that each strap pin keeps its wiring, whether low, high or open, for the whole of a read. An open pin's level is taken to follow the pull code the block drives. The stimulus keeps to these assumptions: pin wiring is chosen only between reads, a pad model turns the pull code into a level on open pins, and `start` is never held for more than one cycle. Extra start pulses are still placed both in the middle of a read and in its final busy cycle, to cover the cases where a start must be ignored.

// File: rtl/strap_pkg.sv
package strap_pkg;

  typedef enum logic [1:0] {
    PULL_NONE = 2'b00,
    PULL_UP   = 2'b01,
    PULL_DOWN = 2'b10
  } pull_e;

  typedef enum logic [1:0] {
    ST_IDLE    = 2'd0,
    ST_UP_WAIT = 2'd1,
    ST_DN_WAIT = 2'd2,
    ST_PACK    = 2'd3
  } state_e;

  function automatic longint pow3(input int n);
    longint r;
    r = 1;
    for (int i = 0; i < n; i++) r = r * 3;
    return r;
  endfunction

endpackage

// File: rtl/strap_sync.sv
module strap_sync #(
  parameter int WIDTH  = 4,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);

  logic [WIDTH-1:0] stg [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    if (s == 0) begin : g_first
      always_ff @(posedge clk) begin
        if (rst) stg[s] <= '0;
        else     stg[s] <= d;
      end
    end else begin : g_rest
      always_ff @(posedge clk) begin
        if (rst) stg[s] <= '0;
        else     stg[s] <= stg[s-1];
      end
    end
  end

  assign q = stg[STAGES-1];

endmodule

// File: rtl/strap_settle_timer.sv
module strap_settle_timer #(
  parameter int CYCLES = 2500
) (
  input  logic clk,
  input  logic rst,
  input  logic load,
  output logic expired
);

  localparam int CNT_W = (CYCLES > 1) ? $clog2(CYCLES) : 1;

  logic [CNT_W-1:0] cnt;
  logic             running;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt     <= '0;
      running <= 1'b0;
    end else if (load) begin
      cnt     <= CNT_W'(CYCLES - 1);
      running <= 1'b1;
    end else if (running) begin
      if (cnt == '0) running <= 1'b0;
      else           cnt     <= cnt - 1'b1;
    end
  end

  assign expired = running && (cnt == '0);

endmodule

// File: rtl/strap_id_packer.sv
module strap_id_packer #(
  parameter int W = 7
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         clear,
  input  logic         step,
  input  logic [1:0]   digit,
  output logic [W-1:0] acc,
  output logic [W-1:0] acc_next
);

  // times three by shift and add, then append the new least significant digit
  assign acc_next = acc + {acc[W-2:0], 1'b0} + W'(digit);

  always_ff @(posedge clk) begin
    if (rst || clear) acc <= '0;
    else if (step)    acc <= acc_next;
  end

endmodule

// File: rtl/strap_ternary_reader.sv
module strap_ternary_reader #(
  parameter int NUM_PINS    = 4,
  parameter int CLK_FREQ_HZ = 250_000_000,
  parameter int SETTLE_US   = 10,
  parameter int SYNC_STAGES = 2,
  localparam int ID_W       = $clog2(strap_pkg::pow3(NUM_PINS))
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  start,
  input  logic [NUM_PINS-1:0]   pin_in,
  output logic                  busy,
  output logic                  done,
  output logic [ID_W-1:0]       id_out,
  output logic [2*NUM_PINS-1:0] pull_sel,
  output logic [NUM_PINS-1:0]   in_buf_en,
  output logic [NUM_PINS-1:0]   out_drv_en,
  output logic [NUM_PINS-1:0]   irq_en,
  output logic [NUM_PINS-1:0]   gpio_sel
);
  import strap_pkg::*;

  localparam longint RAW_SETTLE = (longint'(CLK_FREQ_HZ) * SETTLE_US + 999_999) / 1_000_000;
  localparam int     MIN_SETTLE = SYNC_STAGES + 1;
  localparam int     SETTLE_CYC = (RAW_SETTLE > MIN_SETTLE) ? int'(RAW_SETTLE) : MIN_SETTLE;
  localparam int     IDX_W      = (NUM_PINS > 1) ? $clog2(NUM_PINS) : 1;

  localparam logic [2*NUM_PINS-1:0] ALL_UP   = {NUM_PINS{PULL_UP}};
  localparam logic [2*NUM_PINS-1:0] ALL_DOWN = {NUM_PINS{PULL_DOWN}};

  state_e              state;
  logic [NUM_PINS-1:0] pin_s;
  logic [NUM_PINS-1:0] up_smp;
  logic [NUM_PINS-1:0] dn_smp;
  logic [IDX_W-1:0]    idx;
  logic [1:0]          digit_vec [NUM_PINS];
  logic [1:0]          cur_digit;
  logic [ID_W-1:0]     acc;
  logic [ID_W-1:0]     acc_nx;
  logic                tmr_load;
  logic                tmr_exp;
  logic                pk_clear;
  logic                pk_step;

  strap_sync #(
    .WIDTH (NUM_PINS),
    .STAGES(SYNC_STAGES)
  ) u_sync (
    .clk(clk),
    .rst(rst),
    .d  (pin_in),
    .q  (pin_s)
  );

  strap_settle_timer #(
    .CYCLES(SETTLE_CYC)
  ) u_timer (
    .clk    (clk),
    .rst    (rst),
    .load   (tmr_load),
    .expired(tmr_exp)
  );

  for (genvar i = 0; i < NUM_PINS; i++) begin : g_digit
    assign digit_vec[i] = {up_smp[i] ^ dn_smp[i], dn_smp[i]};
  end

  assign cur_digit = digit_vec[idx];

  strap_id_packer #(
    .W(ID_W)
  ) u_pack (
    .clk     (clk),
    .rst     (rst),
    .clear   (pk_clear),
    .step    (pk_step),
    .digit   (cur_digit),
    .acc     (acc),
    .acc_next(acc_nx)
  );

  always_comb begin
    tmr_load = ((state == ST_IDLE) && start) || ((state == ST_UP_WAIT) && tmr_exp);
    pk_clear = (state == ST_DN_WAIT) && tmr_exp;
    pk_step  = (state == ST_PACK);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state      <= ST_IDLE;
      up_smp     <= '0;
      dn_smp     <= '0;
      idx        <= '0;
      busy       <= 1'b0;
      done       <= 1'b0;
      id_out     <= '0;
      pull_sel   <= '0;
      in_buf_en  <= '0;
      out_drv_en <= '0;
      irq_en     <= '0;
      gpio_sel   <= '0;
    end else begin
      done <= 1'b0;
      case (state)
        ST_IDLE: begin
          if (start) begin
            state      <= ST_UP_WAIT;
            busy       <= 1'b1;
            pull_sel   <= ALL_UP;
            in_buf_en  <= '1;
            gpio_sel   <= '1;
            out_drv_en <= '0;
            irq_en     <= '0;
          end
        end
        ST_UP_WAIT: begin
          if (tmr_exp) begin
            up_smp   <= pin_s;
            pull_sel <= ALL_DOWN;
            state    <= ST_DN_WAIT;
          end
        end
        ST_DN_WAIT: begin
          if (tmr_exp) begin
            dn_smp <= pin_s;
            idx    <= IDX_W'(NUM_PINS - 1);
            state  <= ST_PACK;
          end
        end
        ST_PACK: begin
          if (idx == '0) begin
            id_out   <= acc_nx;
            done     <= 1'b1;
            busy     <= 1'b0;
            pull_sel <= '0;
            state    <= ST_IDLE;
          end else begin
            idx <= idx - 1'b1;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/strap_reader_chk.sv
module strap_reader_chk #(
  parameter int NUM_PINS = 4,
  parameter int ID_W     = 7
) (
  input logic                  clk,
  input logic                  rst,
  input logic                  busy,
  input logic                  done,
  input logic [ID_W-1:0]       id_out,
  input logic [2*NUM_PINS-1:0] pull_sel,
  input logic [NUM_PINS-1:0]   in_buf_en,
  input logic [NUM_PINS-1:0]   out_drv_en,
  input logic [NUM_PINS-1:0]   irq_en,
  input logic [NUM_PINS-1:0]   gpio_sel
);
  localparam longint MAX_ID = strap_pkg::pow3(NUM_PINS) - 1;
  localparam logic [2*NUM_PINS-1:0] UP_CODES = {NUM_PINS{2'b01}};
  localparam logic [2*NUM_PINS-1:0] DN_CODES = {NUM_PINS{2'b10}};

  // R2
  pad_cfg_chk: assert property (@(posedge clk) disable iff (rst)
    busy |-> ((&in_buf_en) && (&gpio_sel) && (out_drv_en == '0) && (irq_en == '0)));

  // R3
  first_pull_up_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(busy) |-> (pull_sel == UP_CODES));

  // R3
  pull_code_chk: assert property (@(posedge clk) disable iff (rst)
    busy |-> ((pull_sel == UP_CODES) || (pull_sel == DN_CODES)));

  // R7
  done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  // R7
  done_busy_excl_chk: assert property (@(posedge clk) disable iff (rst)
    !(done && busy));

  // R7
  busy_end_done_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(busy) |-> done);

  // R8
  idle_release_chk: assert property (@(posedge clk) disable iff (rst)
    !busy |-> (pull_sel == '0));

  // R9
  id_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !$stable(id_out) |-> done);

  // R6
  id_range_chk: assert property (@(posedge clk) disable iff (rst)
    done |-> (longint'(id_out) <= MAX_ID));

endmodule

bind strap_ternary_reader strap_reader_chk #(
  .NUM_PINS(NUM_PINS),
  .ID_W    (ID_W)
) u_chk (
  .clk       (clk),
  .rst       (rst),
  .busy      (busy),
  .done      (done),
  .id_out    (id_out),
  .pull_sel  (pull_sel),
  .in_buf_en (in_buf_en),
  .out_drv_en(out_drv_en),
  .irq_en    (irq_en),
  .gpio_sel  (gpio_sel)
);

// File: tb/strap_ternary_reader_bench.sv
`timescale 1ns/1ps
module strap_ternary_reader_bench;

  localparam int N     = 5;
  localparam int FREQ  = 25_000_000;
  localparam int US    = 10;
  localparam int S     = (FREQ / 1_000_000) * US;   // 250, above SYNC_STAGES + 1
  localparam int IDW   = 8;                         // holds 3^5 - 1 = 242
  localparam int DONE_K = 2 * S + N;

  logic           clk = 1'b0;
  logic           rst = 1'b1;
  logic           start = 1'b0;
  logic [N-1:0]   pin_in;
  logic           busy, done;
  logic [IDW-1:0] id_out;
  logic [2*N-1:0] pull_sel;
  logic [N-1:0]   in_buf_en, out_drv_en, irq_en, gpio_sel;

  int kind [N];   // 0 tied low, 1 tied high, 2 open
  int n_checks = 0;
  int n_fail   = 0;
  longint prev_id = 0;

  always #2 clk = ~clk;

  strap_ternary_reader #(
    .NUM_PINS   (N),
    .CLK_FREQ_HZ(FREQ),
    .SETTLE_US  (US),
    .SYNC_STAGES(2)
  ) u_strap_ternary_reader (
    .clk(clk), .rst(rst), .start(start), .pin_in(pin_in),
    .busy(busy), .done(done), .id_out(id_out), .pull_sel(pull_sel),
    .in_buf_en(in_buf_en), .out_drv_en(out_drv_en), .irq_en(irq_en),
    .gpio_sel(gpio_sel)
  );

  // pad model: open pins follow the applied pull, resting low without one
  always_comb begin
    for (int i = 0; i < N; i++) begin
      if (kind[i] == 0)      pin_in[i] = 1'b0;
      else if (kind[i] == 1) pin_in[i] = 1'b1;
      else                   pin_in[i] = (pull_sel[2*i +: 2] == 2'b01);
    end
  end

  function automatic longint expected_id();
    longint v = 0;
    for (int i = N - 1; i >= 0; i--) v = v * 3 + kind[i];
    return v;
  endfunction

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // one read; extra start pulses at k = ign_a and k = ign_b (negative disables)
  task automatic run_read(input int ign_a, input int ign_b);
    longint exp = expected_id();
    @(negedge clk) start = 1'b1;
    @(negedge clk) start = 1'b0;                    // k = 0
    check(busy == 1'b1, "R2 busy", busy, 1);
    check((&in_buf_en) && (&gpio_sel) && out_drv_en == '0 && irq_en == '0,
          "R2 pad cfg", {in_buf_en, gpio_sel, out_drv_en, irq_en},
          {{N{1'b1}}, {N{1'b1}}, {2*N{1'b0}}});
    check(pull_sel == {N{2'b01}}, "R3 pull-up first", pull_sel, {N{2'b01}});
    for (int k = 1; k <= DONE_K + 1; k++) begin
      @(negedge clk);
      start = (k == ign_a || k == ign_b);
      if (k == 10)
        check(longint'(id_out) == prev_id, "R9 id held during read", id_out, prev_id);
      if (k == S - 1)
        check(pull_sel == {N{2'b01}}, "R4 pull-up lasts S", pull_sel, {N{2'b01}});
      if (k == S)
        check(pull_sel == {N{2'b10}}, "R4 pull-down at S", pull_sel, {N{2'b10}});
      if (k == DONE_K - 1)
        check(busy && !done, "R7 still busy", {busy, done}, 2'b10);
      if (k == DONE_K) begin
        check(done && !busy, "R7 done timing", {busy, done}, 2'b01);
        check(longint'(id_out) == exp, "R6 R5 id value", id_out, exp);
        check(pull_sel == '0 && (&in_buf_en) && (&gpio_sel), "R8 release",
              pull_sel, 0);
      end
      if (k == DONE_K + 1) begin
        check(!done && !busy, "R7 R9 single pulse, no restart", {busy, done}, 0);
        check(longint'(id_out) == exp, "R9 id holds", id_out, exp);
      end
    end
    start = 1'b0;
    prev_id = exp;
    repeat (3) @(negedge clk);
  endtask

  task automatic set_all(input int v);
    for (int i = 0; i < N; i++) kind[i] = v;
  endtask

  initial begin
    void'($urandom(32'h5eed_1234));
    set_all(0);
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R1 reset state
    check(!busy && !done && id_out == '0 && pull_sel == '0 && in_buf_en == '0 &&
          gpio_sel == '0 && out_drv_en == '0 && irq_en == '0, "R1 reset state",
          {busy, done, id_out}, 0);
    rst = 1'b0;
    @(negedge clk);
    check(!busy && !done && pull_sel == '0 && id_out == '0, "R1 after reset",
          {busy, done, id_out}, 0);

    set_all(0); run_read(-1, -1);                     // R5 all low -> 0
    set_all(1); run_read(-1, -1);                     // R5 all high -> 121
    set_all(2); run_read(100, -1);                    // R5 all open -> 242, R9 mid start
    set_all(0); kind[0] = 2; run_read(-1, DONE_K - 1); // R6 pin 0 lsd, R9 late start
    set_all(0); kind[N-1] = 1; run_read(S, -1);       // R6 top digit, start at phase switch
    for (int i = 0; i < N; i++) kind[i] = i % 3;
    run_read(-1, -1);
    for (int r = 0; r < 20; r++) begin
      for (int i = 0; i < N; i++) kind[i] = $urandom_range(2, 0);
      run_read((r % 4 == 0) ? 1 + (r * 37) % (2 * S) : -1, -1);
    end

    $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
    $finish;
  end

  initial begin
    repeat (200_000) @(posedge clk);
    n_checks++;
    n_fail++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
    $finish;
  end

endmodule